// File: doc/BRIEF.md
# Legacy Pin Interrupt Message Generator

This block turns four level-style interrupt status lines from an application into requests for legacy interrupt assert and deassert messages, as a PCI Express endpoint sends them. Each line stands for one of the interrupt pins A to D. A rising level asks for an assert message for that pin. A falling level asks for a deassert message, but only when an assert for that pin has actually gone out. A single disable input, driven by the owning function's configuration, makes the lines have no effect while it is set.

Requests go to a simple transmit side over a valid/ready handshake. The transmit side later confirms delivery with a one-cycle sent strobe. The block then pulses an acknowledge back to the application. The application is expected to wait for that acknowledge before it changes any status line again. If it does not wait, the extra transition is kept pending and served later. It is never lost.

Top module: `intx_msg_gen`

## Requirements
- R1: A low-to-high change on status line p (with disable low) produces one message request with `msg_pin_o` = p (code 00=A, 01=B, 10=C, 11=D) and `msg_assert_o` = 1.
- R2: A high-to-low change on line p, after an assert for p has been sent and not yet withdrawn, produces one request with `msg_pin_o` = p and `msg_assert_o` = 0.
- R3: A high-to-low change on a line for which no assert is outstanding produces no request and no acknowledge.
- R4: While `irq_dis_i` is 1, changes on the status lines produce no request. When `irq_dis_i` returns to 0, levels that changed while it was set cause no request.
- R5: `msg_valid_o` stays high, with `msg_pin_o` and `msg_assert_o` unchanged, until a cycle in which `msg_ready_i` is high. In the following cycle it is low.
- R6: `ack_o` is high for exactly one cycle: the cycle after `msg_sent_i` is sampled high while an accepted request is outstanding. A sent strobe with nothing outstanding gives no acknowledge.
- R7: A transition that arrives while a request is outstanding is held and issued after the current one is acknowledged. Among pending requests, the lowest pin code is served first, and for the same pin an assert goes before a deassert.
- R8: During and right after reset, `msg_valid_o` and `ack_o` are low, and no request appears until a status line changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lvl_i | input | NUM_PINS | Interrupt status levels, bit 0 = pin A |
| irq_dis_i | input | 1 | Interrupt disable of the function |
| msg_valid_o | output | 1 | Message request valid |
| msg_ready_i | input | 1 | Transmit side accepts the request |
| msg_pin_o | output | PIN_W | Pin code of the request |
| msg_assert_o | output | 1 | 1 = assert message, 0 = deassert message |
| msg_sent_i | input | 1 | Strobe: accepted message has been transmitted |
| ack_o | output | 1 | One-cycle acknowledge to the application |

## Verification
The hardest cases to reach are those where the application breaks the handshake: a transition arrives while a request sits between acceptance and the sent strobe, or two lines change in the same cycle. The bench does this on purpose. It raises a second line right after a request is accepted, and it drops two asserted lines together. It then checks that the held requests come out later, in pin order. The disable cases are reached by changing levels while the disable input is set. The bench then clears the disable and watches for stray requests over a quiet window.

// File: rtl/intx_pkg.sv
package intx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OFFER = 2'd1,
    ST_WAIT  = 2'd2
  } intx_state_e;
endpackage

// File: rtl/intx_edge_track.sv
module intx_edge_track #(
  parameter int NUM_PINS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] lvl_i,
  input  logic                dis_i,
  input  logic [NUM_PINS-1:0] asserted_i,
  input  logic [NUM_PINS-1:0] clr_a_i,
  input  logic [NUM_PINS-1:0] clr_d_i,
  output logic [NUM_PINS-1:0] pend_a_o,
  output logic [NUM_PINS-1:0] pend_d_o
);
  logic [NUM_PINS-1:0] lvl_q;

  // The level copy follows the inputs even while disabled, so no stale edge survives
  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= lvl_i;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic rise, fall;
    assign rise = lvl_i[p] & ~lvl_q[p] & ~dis_i;
    assign fall = ~lvl_i[p] & lvl_q[p] & ~dis_i;

    always_ff @(posedge clk) begin
      if (rst) begin
        pend_a_o[p] <= 1'b0;
        pend_d_o[p] <= 1'b0;
      end else begin
        pend_a_o[p] <= (pend_a_o[p] & ~clr_a_i[p]) | rise;
        // a withdrawal is only worth queuing if an assert is out or on its way
        pend_d_o[p] <= (pend_d_o[p] & ~clr_d_i[p]) |
                       (fall & (asserted_i[p] | pend_a_o[p]));
      end
    end
  end
endmodule

// File: rtl/intx_arbiter.sv
module intx_arbiter #(
  parameter int NUM_PINS = 4,
  parameter int PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic [NUM_PINS-1:0] pend_a_i,
  input  logic [NUM_PINS-1:0] pend_d_i,
  input  logic [NUM_PINS-1:0] asserted_i,
  output logic                gnt_valid_o,
  output logic [PIN_W-1:0]    gnt_pin_o,
  output logic                gnt_assert_o
);
  logic [NUM_PINS-1:0] elig_d;

  // a deassert waits until its pin's assert has gone out
  assign elig_d = pend_d_i & asserted_i & ~pend_a_i;

  // scan from the top so the lowest pin index is the one left standing
  always_comb begin
    gnt_valid_o  = 1'b0;
    gnt_pin_o    = '0;
    gnt_assert_o = 1'b0;
    for (int p = NUM_PINS - 1; p >= 0; p--) begin
      if (pend_a_i[p]) begin
        gnt_valid_o  = 1'b1;
        gnt_pin_o    = PIN_W'(p);
        gnt_assert_o = 1'b1;
      end else if (elig_d[p]) begin
        gnt_valid_o  = 1'b1;
        gnt_pin_o    = PIN_W'(p);
        gnt_assert_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/intx_msg_ctrl.sv
module intx_msg_ctrl
  import intx_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                gnt_valid_i,
  input  logic [PIN_W-1:0]    gnt_pin_i,
  input  logic                gnt_assert_i,
  input  logic                ready_i,
  input  logic                sent_i,
  output logic                valid_o,
  output logic [PIN_W-1:0]    pin_o,
  output logic                assert_o,
  output logic                ack_o,
  output logic [NUM_PINS-1:0] clr_a_o,
  output logic [NUM_PINS-1:0] clr_d_o,
  output logic [NUM_PINS-1:0] asserted_o
);
  intx_state_e state_q;
  logic        done;

  assign done = (state_q == ST_WAIT) && sent_i;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_clr
    assign clr_a_o[p] = done &  assert_o & (pin_o == PIN_W'(p));
    assign clr_d_o[p] = done & ~assert_o & (pin_o == PIN_W'(p));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      valid_o    <= 1'b0;
      pin_o      <= '0;
      assert_o   <= 1'b0;
      ack_o      <= 1'b0;
      asserted_o <= '0;
    end else begin
      ack_o <= 1'b0;
      case (state_q)
        ST_IDLE: if (gnt_valid_i) begin
          valid_o  <= 1'b1;
          pin_o    <= gnt_pin_i;
          assert_o <= gnt_assert_i;
          state_q  <= ST_OFFER;
        end
        ST_OFFER: if (ready_i) begin
          valid_o <= 1'b0;
          state_q <= ST_WAIT;
        end
        ST_WAIT: if (sent_i) begin
          ack_o             <= 1'b1;
          asserted_o[pin_o] <= assert_o;
          state_q           <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/intx_msg_gen.sv
module intx_msg_gen #(
  parameter int NUM_PINS = 4,
  parameter int PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] irq_lvl_i,
  input  logic                irq_dis_i,
  output logic                msg_valid_o,
  input  logic                msg_ready_i,
  output logic [PIN_W-1:0]    msg_pin_o,
  output logic                msg_assert_o,
  input  logic                msg_sent_i,
  output logic                ack_o
);
  logic [NUM_PINS-1:0] pend_a, pend_d, asserted, clr_a, clr_d;
  logic                gnt_valid, gnt_assert;
  logic [PIN_W-1:0]    gnt_pin;

  intx_edge_track #(.NUM_PINS(NUM_PINS)) u_track (
    .clk(clk), .rst(rst), .lvl_i(irq_lvl_i), .dis_i(irq_dis_i),
    .asserted_i(asserted), .clr_a_i(clr_a), .clr_d_i(clr_d),
    .pend_a_o(pend_a), .pend_d_o(pend_d)
  );

  intx_arbiter #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_arb (
    .pend_a_i(pend_a), .pend_d_i(pend_d), .asserted_i(asserted),
    .gnt_valid_o(gnt_valid), .gnt_pin_o(gnt_pin), .gnt_assert_o(gnt_assert)
  );

  intx_msg_ctrl #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .gnt_valid_i(gnt_valid), .gnt_pin_i(gnt_pin), .gnt_assert_i(gnt_assert),
    .ready_i(msg_ready_i), .sent_i(msg_sent_i),
    .valid_o(msg_valid_o), .pin_o(msg_pin_o), .assert_o(msg_assert_o),
    .ack_o(ack_o), .clr_a_o(clr_a), .clr_d_o(clr_d), .asserted_o(asserted)
  );
endmodule

// File: rtl/intx_msg_gen_chk.sv
module intx_msg_gen_chk #(
  parameter int NUM_PINS = 4,
  parameter int PIN_W    = 2
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_PINS-1:0] irq_lvl_i,
  input logic                irq_dis_i,
  input logic                msg_valid_o,
  input logic                msg_ready_i,
  input logic [PIN_W-1:0]    msg_pin_o,
  input logic                msg_assert_o,
  input logic                msg_sent_i,
  input logic                ack_o
);
  // R5
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_valid_o && !msg_ready_i) |=>
      (msg_valid_o && $stable(msg_pin_o) && $stable(msg_assert_o)));

  // R5
  accept_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_valid_o && msg_ready_i) |=> !msg_valid_o);

  // R6
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    ack_o |=> !ack_o);

  // R6
  ack_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_o) |-> ($past(msg_sent_i) && !$past(msg_valid_o)));

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!msg_valid_o && !ack_o));
endmodule

bind intx_msg_gen intx_msg_gen_chk #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_chk (.*);

// File: tb/test_intx_msg_gen.sv
module test_intx_msg_gen;
  localparam int NP = 4;
  localparam int PW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] lvl = '0;
  logic          dis = 1'b0;
  logic          ready = 1'b0;
  logic          sent = 1'b0;
  logic          valid, m_assert, ack;
  logic [PW-1:0] m_pin;
  int            checks = 0;
  int            failures = 0;

  always #2 clk = ~clk;

  intx_msg_gen #(.NUM_PINS(NP), .PIN_W(PW)) i_intx_msg_gen (
    .clk(clk), .rst(rst), .irq_lvl_i(lvl), .irq_dis_i(dis),
    .msg_valid_o(valid), .msg_ready_i(ready), .msg_pin_o(m_pin),
    .msg_assert_o(m_assert), .msg_sent_i(sent), .ack_o(ack)
  );

  // entry: {pin[1:0], new level, message expected, assert type}
  localparam logic [4:0] VEC [8] = '{
    {2'd0, 1'b1, 1'b1, 1'b1},
    {2'd1, 1'b1, 1'b1, 1'b1},
    {2'd0, 1'b0, 1'b1, 1'b0},
    {2'd3, 1'b1, 1'b1, 1'b1},
    {2'd2, 1'b1, 1'b1, 1'b1},
    {2'd2, 1'b0, 1'b1, 1'b0},
    {2'd1, 1'b0, 1'b1, 1'b0},
    {2'd3, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_pin(input int p, input logic v);
    @(negedge clk);
    lvl[p] = v;
  endtask

  task automatic expect_quiet(input int n, input string req);
    logic seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (valid || ack) seen = 1'b1;
    end
    chk(!seen, req, int'(seen), 0);
  endtask

  // waits for a request, checks it, holds off ready, then completes the handshake
  task automatic serve(input int p, input logic a, input string req,
                       input logic late_rise = 1'b0, input int late_pin = 0);
    int w = 0;
    @(negedge clk);
    while (!valid && w < 20) begin
      @(negedge clk);
      w++;
    end
    chk(valid, req, int'(valid), 1);
    chk(m_pin == PW'(p), req, int'(m_pin), p);
    chk(m_assert == a, req, int'(m_assert), int'(a));
    repeat (2) @(negedge clk);
    chk(valid && m_pin == PW'(p), "R5 hold", int'(valid), 1);
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
    chk(!valid, "R5 drop", int'(valid), 0);
    if (late_rise) begin
      $display("note: protocol violation injected on pin %0d", late_pin);
      lvl[late_pin] = 1'b1;
    end
    @(negedge clk);
    chk(!ack, "R6 no early ack", int'(ack), 0);
    sent = 1'b1;
    @(negedge clk);
    sent = 1'b0;
    chk(ack, "R6 ack", int'(ack), 1);
    @(negedge clk);
    chk(!ack, "R6 ack width", int'(ack), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R8: quiet during and after reset
    repeat (3) @(negedge clk);
    chk(!valid && !ack, "R8 in reset", int'(valid), 0);
    rst = 1'b0;
    expect_quiet(6, "R8 after reset");

    // R1 R2: table of transitions
    foreach (VEC[i]) begin
      set_pin(int'(VEC[i][4:3]), VEC[i][2]);
      if (VEC[i][1]) serve(int'(VEC[i][4:3]), VEC[i][0], VEC[i][0] ? "R1 assert" : "R2 deassert");
      else expect_quiet(8, "R3 none");
    end

    // R4 and R3: change while disabled, no stale edge, fall without assert
    @(negedge clk); dis = 1'b1;
    set_pin(2, 1'b1);
    expect_quiet(6, "R4 disabled rise");
    dis = 1'b0;
    expect_quiet(6, "R4 no stale edge");
    set_pin(2, 1'b0);
    expect_quiet(8, "R3 fall without assert");

    // R4: withdrawal ignored while disabled, then a fresh rise asserts again
    set_pin(0, 1'b1);
    serve(0, 1'b1, "R1 assert A");
    @(negedge clk); dis = 1'b1;
    set_pin(0, 1'b0);
    expect_quiet(6, "R4 disabled fall");
    dis = 1'b0;
    expect_quiet(6, "R4 clear quiet");
    set_pin(0, 1'b1);
    serve(0, 1'b1, "R1 re-assert A");
    set_pin(0, 1'b0);
    serve(0, 1'b0, "R2 deassert A");

    // R7: transition during an outstanding request is held
    set_pin(1, 1'b1);
    serve(1, 1'b1, "R7 first", 1'b1, 3);
    serve(3, 1'b1, "R7 held D");

    // R7: simultaneous falls served lowest pin first
    @(negedge clk);
    $display("note: protocol violation injected, two lines at once");
    lvl[1] = 1'b0;
    lvl[3] = 1'b0;
    serve(1, 1'b0, "R7 order B");
    serve(3, 1'b0, "R7 order D");

    // R7: assert before deassert on the same pin (rise then fall while busy)
    set_pin(2, 1'b1);
    set_pin(2, 1'b0);
    $display("note: protocol violation injected, pulse on pin 2");
    serve(2, 1'b1, "R7 assert first");
    serve(2, 1'b0, "R7 then deassert");

    // R6: sent strobe with nothing outstanding
    @(negedge clk); sent = 1'b1;
    @(negedge clk); sent = 1'b0;
    expect_quiet(4, "R6 stray sent");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule